// File: doc/BRIEF.md
# Dual-Mode Converter Serial Output Port

This block sends one 24-bit conversion result, most significant bit first, on a single data line. A conversion sequencer gives it the result as a parallel word with a one-cycle strobe. The port then pulls its active-low ready output low and holds it low until the word has been read out. A mode input picks who clocks the transfer. In master mode the port makes its own shift clock at half the master clock rate, with fixed master-clock delays around ready and chip select. In slave mode a host supplies the shift clock, which may run without a break or in bursts. The port samples that clock through a synchronizer.

Chip select is active low and gates both outputs. While it is high, the data line is released and, in master mode, so is the shift clock. Release is modelled with an output-enable signal for each line. The receiver samples on the shift-clock rising edge, so the port changes data only after a falling edge. A read can begin with chip select already low when ready falls, or chip select can fall later. If chip select rises part way through a word, that transfer is dropped and the next selection starts again from the most significant bit.

Top module: `sout_port`

## Requirements
- R1: After reset, `rdy_no` is 1, `sclk_o` is 0, and both output enables are 0 while `cs_ni` is 1.
- R2: While `rdy_no` is 1, a `word_valid_i` pulse captures `word_i` and the level of `slave_mode_i`, and `rdy_no` reads 0 after that edge. While `rdy_no` is 0, `word_valid_i` is ignored: the word being read does not change.
- R3: `sdo_oe_o` equals the inverse of `cs_ni` in both modes. `sclk_oe_o` is 1 only when `cs_ni` is 0 and the mode in effect is master. The mode in effect is `slave_mode_i` while `rdy_no` is 1, and otherwise the mode captured with the word (0 = master, 1 = slave).
- R4: Master mode, chip select low at the edge where ready falls: `sdo_o` carries the MSB from 2 cycles after `rdy_no` falls, and the first `sclk_o` rising edge comes 4 cycles after `rdy_no` falls.
- R5: Master mode: `sclk_o` is high for one cycle and low for one cycle, giving exactly 24 rising edges per word. At rising edge k (k = 0..23), `sdo_o` holds bit 23-k. `sdo_o` moves to the next bit in the cycle where `sclk_o` falls.
- R6: Master mode: `rdy_no` returns to 1 8 cycles after the last `sclk_o` rising edge.
- R7: Master mode, chip select low only after ready has fallen: the first `sclk_o` rising edge comes 8 cycles after the first clock edge that samples `cs_ni` low, and the MSB is on `sdo_o` 2 cycles before that rising edge.
- R8: Master mode: if `cs_ni` rises during the lead-in or the shifting phase, `sclk_o` goes low and stays low, and `rdy_no` stays 0. When `cs_ni` falls again, all 24 bits are sent again from the MSB with R7 timing.
- R9: Slave mode: `sdo_o` carries the MSB from the cycle `rdy_no` falls. Each falling edge of `sclk_i` that follows a counted rising edge moves `sdo_o` to the next bit, 3 master clock cycles after the change. The bit stays stable across the host rising edge. Pauses in the host clock are allowed.
- R10: Slave mode: `rdy_no` stays 0 after the 24th rising edge of `sclk_i` and becomes 1 after the falling edge that follows it, within 3 cycles.
- R11: Slave mode: `cs_ni` going high part way through a word clears the bit count and puts the MSB back on `sdo_o`. Edges of `sclk_i` are ignored while `cs_ni` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 0 = port makes the shift clock, 1 = host provides it |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Host shift clock (slave mode), asynchronous |
| word_valid_i | input | 1 | One-cycle strobe: new conversion word available |
| word_i | input | 24 | Conversion word |
| rdy_no | output | 1 | Data ready, active low |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o`; 0 means high impedance |
| sclk_o | output | 1 | Generated shift clock (master mode) |
| sclk_oe_o | output | 1 | Drive enable for `sclk_o`; 0 means high impedance |

## Verification
The assertions assume that `slave_mode_i` changes only while ready is high. They also assume that the host clock is held between toggles long enough for the three-cycle synchronizer to see every level, which in practice means at least four master clocks per phase. The stimulus switches modes only between words and toggles `sclk_i` every four master clocks or more slowly. It also drives chip select only at falling master-clock edges, so each change is sampled at a known rising edge and the 2-, 4- and 8-cycle windows can be counted exactly.

// File: rtl/sout_pkg.sv
package sout_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_WAIT,
    M_LEAD,
    M_SHIFT,
    M_TAIL
  } mst_state_e;

  typedef enum logic {
    S_IDLE,
    S_ARMED
  } slv_state_e;
endpackage

// File: rtl/sout_edge_sync.sv
module sout_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sout_master_ctl.sv
module sout_master_ctl import sout_pkg::*; #(
  parameter int WORD_W   = 24,
  parameter int RDY_LEAD = 4,
  parameter int CS_LEAD  = 8,
  parameter int MSB_LEAD = 2,
  parameter int TAIL_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cs_ni,
  output logic sclk_o,
  output logic present_o,
  output logic shift_o,
  output logic rewind_o,
  output logic done_o
);
  localparam int LD_MAX = (CS_LEAD > RDY_LEAD) ? CS_LEAD : RDY_LEAD;
  localparam int CNT_MAX = (TAIL_CYC > LD_MAX) ? TAIL_CYC : LD_MAX;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] RDY_LD  = CNT_W'(RDY_LEAD - 1);
  localparam logic [CNT_W-1:0] CS_LD   = CNT_W'(CS_LEAD - 1);
  localparam logic [CNT_W-1:0] TAIL_LD = CNT_W'(TAIL_CYC - 2);
  localparam logic [CNT_W-1:0] MSB_AT  = CNT_W'(MSB_LEAD);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  mst_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bitcnt_q;
  logic             sclk_q;
  logic             in_xfer;

  assign in_xfer   = (state_q == M_LEAD) || (state_q == M_SHIFT);
  assign rewind_o  = in_xfer && cs_ni;
  assign present_o = (state_q == M_LEAD) && !cs_ni && (cnt_q == MSB_AT);
  assign shift_o   = (state_q == M_SHIFT) && !cs_ni && sclk_q && (bitcnt_q != LAST_BIT);
  assign done_o    = (state_q == M_TAIL) && (cnt_q == '0);
  assign sclk_o    = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= M_IDLE;
      cnt_q    <= '0;
      bitcnt_q <= '0;
      sclk_q   <= 1'b0;
    end else begin
      unique case (state_q)
        M_IDLE: if (start_i) begin
          if (!cs_ni) begin
            state_q <= M_LEAD;
            cnt_q   <= RDY_LD;
          end else begin
            state_q <= M_WAIT;
          end
        end
        M_WAIT: if (!cs_ni) begin
          state_q <= M_LEAD;
          cnt_q   <= CS_LD;
        end
        M_LEAD: begin
          if (cs_ni) begin
            state_q <= M_WAIT;
          end else if (cnt_q == '0) begin
            state_q <= M_SHIFT;
            sclk_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        M_SHIFT: begin
          if (cs_ni) begin
            state_q  <= M_WAIT;
            sclk_q   <= 1'b0;
            bitcnt_q <= '0;
          end else if (sclk_q) begin
            sclk_q <= 1'b0;
            if (bitcnt_q == LAST_BIT) begin
              state_q <= M_TAIL;
              cnt_q   <= TAIL_LD;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end else begin
            sclk_q <= 1'b1;
          end
        end
        M_TAIL: begin
          if (cnt_q == '0) begin
            state_q  <= M_IDLE;
            bitcnt_q <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  // R5
  sclk_half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |=> !sclk_q);

  // R8
  cs_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && in_xfer) |=> (state_q == M_WAIT && !sclk_q));

  // R6
  tail_full_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_TAIL) |-> (bitcnt_q == LAST_BIT));
endmodule

// File: rtl/sout_slave_ctl.sv
module sout_slave_ctl import sout_pkg::*; #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic shift_o,
  output logic rewind_o,
  output logic done_o
);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(WORD_W);

  slv_state_e       state_q;
  logic [BIT_W-1:0] bitcnt_q;
  logic             h_rise, h_fall;
  logic             armed_sel;

  sout_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sclk_i),
    .rise_o (h_rise),
    .fall_o (h_fall)
  );

  assign armed_sel = (state_q == S_ARMED) && !cs_ni;
  assign rewind_o  = (state_q == S_ARMED) && cs_ni && (bitcnt_q != '0);
  assign shift_o   = armed_sel && h_fall && (bitcnt_q != '0) && (bitcnt_q != FULL);
  assign done_o    = armed_sel && h_fall && (bitcnt_q == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_ARMED;
          bitcnt_q <= '0;
        end
        S_ARMED: begin
          if (cs_ni) begin
            bitcnt_q <= '0;
          end else if (h_rise && bitcnt_q != FULL) begin
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (h_fall && bitcnt_q == FULL) begin
            state_q  <= S_IDLE;
            bitcnt_q <= '0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  bit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitcnt_q <= FULL);

  // R11
  deselect_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ARMED && cs_ni) |=> (bitcnt_q == '0));
endmodule

// File: rtl/sout_port.sv
module sout_port import sout_pkg::*; #(
  parameter int WORD_W      = 24,
  parameter int RDY_LEAD    = 4,
  parameter int CS_LEAD     = 8,
  parameter int MSB_LEAD    = 2,
  parameter int TAIL_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              rdy_no,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              sclk_o,
  output logic              sclk_oe_o
);
  localparam int MSB = WORD_W - 1;

  logic              rdy_q, mode_q, sdo_q;
  logic [WORD_W-1:0] word_q, shreg_q;
  logic              accept, m_start, s_start;
  logic              m_sclk, m_present, m_shift, m_rewind, m_done;
  logic              s_shift, s_rewind, s_done;
  logic              present, shift, rewind, done, mode_eff;

  assign accept  = word_valid_i && rdy_q;
  assign m_start = accept && !slave_mode_i;
  assign s_start = accept && slave_mode_i;

  sout_master_ctl #(
    .WORD_W   (WORD_W),
    .RDY_LEAD (RDY_LEAD),
    .CS_LEAD  (CS_LEAD),
    .MSB_LEAD (MSB_LEAD),
    .TAIL_CYC (TAIL_CYC)
  ) u_mst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (m_start),
    .cs_ni     (cs_ni),
    .sclk_o    (m_sclk),
    .present_o (m_present),
    .shift_o   (m_shift),
    .rewind_o  (m_rewind),
    .done_o    (m_done)
  );

  sout_slave_ctl #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_slv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (s_start),
    .cs_ni    (cs_ni),
    .sclk_i   (sclk_i),
    .shift_o  (s_shift),
    .rewind_o (s_rewind),
    .done_o   (s_done)
  );

  assign present = !mode_q && m_present;
  assign shift   = mode_q ? s_shift  : m_shift;
  assign rewind  = mode_q ? s_rewind : m_rewind;
  assign done    = mode_q ? s_done   : m_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b1;
      mode_q  <= 1'b0;
      sdo_q   <= 1'b0;
      word_q  <= '0;
      shreg_q <= '0;
    end else if (accept) begin
      rdy_q   <= 1'b0;
      mode_q  <= slave_mode_i;
      word_q  <= word_i;
      shreg_q <= word_i;
      sdo_q   <= slave_mode_i ? word_i[MSB] : 1'b0;
    end else if (!rdy_q) begin
      if (done) rdy_q <= 1'b1;
      if (rewind) begin
        shreg_q <= word_q;
        sdo_q   <= mode_q ? word_q[MSB] : 1'b0;
      end else if (present) begin
        sdo_q <= shreg_q[MSB];
      end else if (shift) begin
        shreg_q <= {shreg_q[MSB-1:0], 1'b0};
        sdo_q   <= shreg_q[MSB-1];
      end
    end
  end

  assign mode_eff  = rdy_q ? slave_mode_i : mode_q;
  assign rdy_no    = rdy_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = !cs_ni;
  assign sclk_o    = m_sclk;
  assign sclk_oe_o = !cs_ni && !mode_eff;

  // R2
  accept_lowers_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !rdy_q);

  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && !done) |=> !rdy_q);

  // R5
  no_slave_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && mode_q) |-> !m_sclk);
endmodule

// File: tb/sout_port_tb_top.sv
module sout_port_tb_top;
  localparam int W = 24;
  localparam int RDY_LEAD = 4;
  localparam int CS_LEAD = 8;
  localparam int MSB_LEAD = 2;
  localparam int TAIL = 8;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_mode_i = 1'b0;
  logic cs_ni = 1'b1;
  logic sclk_i = 1'b0;
  logic word_valid_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic rdy_no, sdo_o, sdo_oe_o, sclk_o, sclk_oe_o;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sout_port dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .slave_mode_i (slave_mode_i),
    .cs_ni        (cs_ni),
    .sclk_i       (sclk_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_i),
    .rdy_no       (rdy_no),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o),
    .sclk_o       (sclk_o),
    .sclk_oe_o    (sclk_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic accept_word(input logic [W-1:0] w);
    word_i = w;
    word_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid_i = 1'b0;
    chk(rdy_no == 1'b0, "R2 ready low after strobe", int'(rdy_no), 0);
  endtask

  // cs_late < 0: chip select already low when ready falls
  task automatic master_run(input logic [W-1:0] w, input bit do_accept, input int cs_late);
    int first_exp, nrise, last_rise, rdy_rise;
    bit prev_sclk, prev_rdy;
    string tag;
    first_exp = (cs_late < 0) ? RDY_LEAD : cs_late + 1 + CS_LEAD;
    tag = (cs_late < 0) ? "R4" : "R7";
    if (do_accept) accept_word(w);
    if (cs_late >= 0)
      chk(!sdo_oe_o && !sclk_oe_o, "R3 released while deselected", int'(sdo_oe_o), 0);
    nrise = 0; last_rise = -1; rdy_rise = -1;
    prev_sclk = 1'b0; prev_rdy = rdy_no;
    for (int idx = 0; idx < 300 && rdy_rise < 0; idx++) begin
      if (idx > 0) @(negedge clk);
      if (idx == first_exp - MSB_LEAD)
        chk(sdo_o == w[W-1], {tag, " MSB lead"}, int'(sdo_o), int'(w[W-1]));
      if (sclk_o && !prev_sclk) begin
        chk(idx == first_exp + 2 * nrise, {tag, "/R5 rise timing"}, idx, first_exp + 2 * nrise);
        if (nrise < W) chk(sdo_o == w[W-1-nrise], "R5 bit at rise", int'(sdo_o), int'(w[W-1-nrise]));
        last_rise = idx;
        nrise++;
      end
      if (!sclk_o && prev_sclk && nrise < W)
        chk(sdo_o == w[W-1-nrise], "R5 bit after fall", int'(sdo_o), int'(w[W-1-nrise]));
      if (rdy_no && !prev_rdy) rdy_rise = idx;
      if (!cs_ni)
        chk(sdo_oe_o && sclk_oe_o, "R3 driven while selected", int'(sclk_oe_o), 1);
      prev_sclk = sclk_o;
      prev_rdy = rdy_no;
      if (cs_late >= 0 && idx == cs_late) cs_ni = 1'b0;
    end
    chk(nrise == W, "R5 rise count", nrise, W);
    chk(rdy_rise == last_rise + TAIL, "R6 ready return", rdy_rise, last_rise + TAIL);
  endtask

  task automatic master_abort(input logic [W-1:0] w, input int k);
    int nrise;
    bit prev;
    cs_ni = 1'b0;
    accept_word(w);
    nrise = 0; prev = 1'b0;
    while (nrise < k) begin
      @(negedge clk);
      if (sclk_o && !prev) nrise++;
      prev = sclk_o;
    end
    cs_ni = 1'b1;
    word_i = ~w;
    word_valid_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      word_valid_i = 1'b0;
      chk(!sclk_o && !rdy_no && !sdo_oe_o && !sclk_oe_o, "R8 halted", int'(sclk_o), 0);
    end
    // restart must resend the original word: strobe above was ignored (R2)
    master_run(w, 1'b0, 0);
  endtask

  task automatic slave_shift(input logic [W-1:0] w, input int nbits, input bit gaps);
    for (int k = 0; k < nbits; k++) begin
      chk(sdo_o == w[W-1-k], "R9 bit before rise", int'(sdo_o), int'(w[W-1-k]));
      sclk_i = 1'b1;
      repeat (H) @(negedge clk);
      chk(sdo_o == w[W-1-k], "R9 bit held after rise", int'(sdo_o), int'(w[W-1-k]));
      if (k == W - 1) chk(rdy_no == 1'b0, "R10 ready low before last fall", int'(rdy_no), 0);
      sclk_i = 1'b0;
      repeat (H + ((gaps && (k % 3 == 0)) ? 9 : 0)) @(negedge clk);
    end
    if (nbits == W) chk(rdy_no == 1'b1, "R10 ready after last fall", int'(rdy_no), 1);
  endtask

  task automatic slave_read(input logic [W-1:0] w, input bit gaps);
    slave_mode_i = 1'b1;
    cs_ni = 1'b0;
    accept_word(w);
    chk(sdo_o == w[W-1], "R9 MSB at ready", int'(sdo_o), int'(w[W-1]));
    chk(sdo_oe_o && !sclk_oe_o, "R3 slave enables", int'(sclk_oe_o), 0);
    slave_shift(w, W, gaps);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy_no && !sclk_o && !sdo_oe_o && !sclk_oe_o, "R1 reset state", int'(rdy_no), 1);

    // master, chip select already low: walking ones and dense patterns
    cs_ni = 1'b0;
    @(negedge clk);
    for (int b = 0; b < W; b++) master_run(W'(1) << b, 1'b1, -1);
    master_run(24'hA5C3F0, 1'b1, -1);
    master_run(24'hFFFFFF, 1'b1, -1);
    master_run(24'h000000, 1'b1, -1);

    // master, chip select falling after ready
    for (int d = 0; d < 6; d++) begin
      cs_ni = 1'b1;
      @(negedge clk);
      pat = 24'h5A0F3C ^ W'(d * 24'h111111);
      master_run(pat, 1'b1, d);
    end

    // R8 aborts at several depths
    cs_ni = 1'b1;
    @(negedge clk);
    master_abort(24'h9E3779, 5);
    cs_ni = 1'b1;
    @(negedge clk);
    master_abort(24'hC0FFEE, 1);
    cs_ni = 1'b1;
    @(negedge clk);

    // slave mode
    slave_mode_i = 1'b1;
    @(negedge clk);
    chk(!sclk_oe_o && !sdo_oe_o, "R3 slave idle deselected", int'(sclk_oe_o), 0);
    slave_read(24'h813FA7, 1'b0);
    slave_read(24'h7EC058, 1'b1);
    for (int b = 0; b < W; b += 5) slave_read(W'(1) << b, b[0]);

    // R11 slave abort and restart
    cs_ni = 1'b0;
    accept_word(24'hB1D2E3);
    slave_shift(24'hB1D2E3, 7, 1'b0);
    cs_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sdo_oe_o && !rdy_no, "R11 released and pending", int'(rdy_no), 0);
    sclk_i = 1'b1;
    repeat (H) @(negedge clk);
    sclk_i = 1'b0;
    repeat (H) @(negedge clk);
    cs_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdo_o == 1'b1, "R11 MSB restored", int'(sdo_o), 1);
    slave_shift(24'hB1D2E3, W, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule